// File: doc/BRIEF.md
# CPU Sleep Entry and Wakeup Controller

This block decides when a small microcontroller's CPU core goes to sleep and when it comes back. A wait strobe from the CPU, taken while the standby-select bit is clear, stops the CPU clock on the next edge. The CPU keeps its register contents and the peripheral clocks keep running. In the same cycle as the strobe, the block raises a one-cycle request that sets the CPU's interrupt mask bit.

While the core sleeps, the block watches the winning interrupt request from the interrupt controller. A request counts as a wake event only when its enable is set and its priority is strictly above the CPU's current 4-bit priority level. Such a request restarts the CPU clock one clock later and marks the restart with a single-cycle wake pulse.

The block also gates the watchdog count during sleep. In auto-start mode the option-setting stop bit makes the choice. In register-start mode the register stop-control bit makes the choice. Outside sleep the watchdog always counts.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, cpu_clk_en_o is 1, wdt_cnt_en_o is 1, wake_o is 0 and mask_set_o is 0.
- R2: A wait_i strobe in the run state with stby_sel_i at 0 and no qualifying request drops cpu_clk_en_o to 0 from the next cycle. The clock stays off until a qualifying request arrives.
- R3: A wait_i strobe with stby_sel_i at 1 causes no sleep entry and leaves mask_set_o at 0.
- R4: mask_set_o is 1 in the same cycle as a wait_i strobe that is taken in the run state with stby_sel_i at 0. This holds whether or not a request is pending.
- R5: A request qualifies only when irq_pend_i, irq_en_i are both 1 and irq_prio_i is strictly greater than cpu_ipl_i. A request whose priority equals the level, or whose enable is 0, does not wake the CPU.
- R6: A qualifying request sampled during sleep sets cpu_clk_en_o to 1 on the next cycle. wake_o is 1 for exactly that one cycle.
- R7: A qualifying request in the same cycle as an accepted wait strobe prevents sleep entry. cpu_clk_en_o stays 1 and no wake pulse is produced.
- R8: With wdt_auto_mode_i at 1 (auto-start), wdt_cnt_en_o during sleep equals the inverse of wdt_opt_stop_i. wdt_reg_stop_i has no effect in this mode.
- R9: With wdt_auto_mode_i at 0 (register start), wdt_cnt_en_o during sleep equals the inverse of wdt_reg_stop_i. wdt_opt_stop_i has no effect in this mode.
- R10: Whenever cpu_clk_en_o is 1, wdt_cnt_en_o is 1, whatever the stop bits are.
- R11: A wait_i strobe during sleep is ignored. mask_set_o stays 0 and the CPU clock stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wait_i | input | 1 | Wait-instruction strobe from the CPU |
| stby_sel_i | input | 1 | Standby select; 0 selects sleep |
| cpu_ipl_i | input | PRIO_W | CPU current priority level |
| irq_pend_i | input | 1 | Winning interrupt request pending |
| irq_en_i | input | 1 | Enable bit of the winning request |
| irq_prio_i | input | PRIO_W | Priority of the winning request |
| wdt_auto_mode_i | input | 1 | Watchdog start mode: 1 auto-start, 0 register start |
| wdt_opt_stop_i | input | 1 | Auto-start mode stop-in-sleep bit |
| wdt_reg_stop_i | input | 1 | Register-start mode stop-in-sleep bit |
| cpu_clk_en_o | output | 1 | CPU clock enable; 0 in sleep |
| wdt_cnt_en_o | output | 1 | Watchdog count enable |
| wake_o | output | 1 | One-cycle wake event |
| mask_set_o | output | 1 | Forces the CPU interrupt mask bit to 1 |

## Verification
mask_set_o is combinational, so its value is due in the same cycle as the wait strobe. The bench reads it shortly after driving inputs on the falling edge. cpu_clk_en_o and wake_o come from registers and change one rising edge after the stimulus is sampled, so they are read on the following falling edge, before inputs change again. wdt_cnt_en_o follows the mode and stop bits with no delay once the sleep state is registered, so each mode and bit combination is applied and checked within a single sleeping cycle.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } slp_state_e;
endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual #(
  parameter int PRIO_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic              en_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0] ipl_i,
  output logic              qual_o
);
  logic above;

  assign above  = prio_i > ipl_i;
  assign qual_o = pend_i & en_i & above;

  // strict comparison: equal priority never wakes
  assert_strict_prio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> (prio_i != ipl_i) && en_i);
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic stby_sel_i,
  input  logic qual_i,
  output logic sleep_o,
  output logic wake_o,
  output logic mask_set_o
);
  slp_state_e state_q, state_d;
  logic       wait_ok;
  logic       wake_q;

  assign wait_ok = (state_q == ST_RUN) & wait_i & ~stby_sel_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (wait_ok && !qual_i) state_d = ST_SLEEP;
      ST_SLEEP: if (qual_i) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= (state_q == ST_SLEEP) & qual_i;
    end
  end

  assign sleep_o    = (state_q == ST_SLEEP);
  assign wake_o     = wake_q;
  assign mask_set_o = wait_ok;

  assert_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_o && wait_i && !stby_sel_i && !qual_i) |=> sleep_o);
  assert_stay_asleep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && !qual_i) |=> sleep_o);
  assert_stby_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_o && stby_sel_i) |=> !sleep_o);
  assert_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && qual_i) |=> (!sleep_o && wake_o));
  assert_wake_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  assert_race_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_o && qual_i) |=> (!sleep_o && !wake_o));
  assert_sleep_wait_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !mask_set_o);
endmodule

// File: rtl/slp_wdt_gate.sv
module slp_wdt_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic auto_mode_i,
  input  logic opt_stop_i,
  input  logic reg_stop_i,
  output logic cnt_en_o
);
  logic stop_sel;

  // each start mode owns its stop bit
  assign stop_sel = auto_mode_i ? opt_stop_i : reg_stop_i;
  assign cnt_en_o = ~(sleep_i & stop_sel);

  assert_wdt_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> cnt_en_o);
  assert_wdt_auto_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && auto_mode_i) |-> (cnt_en_o != opt_stop_i));
  assert_wdt_reg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !auto_mode_i) |-> (cnt_en_o != reg_stop_i));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int PRIO_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wait_i,
  input  logic              stby_sel_i,
  input  logic [PRIO_W-1:0] cpu_ipl_i,
  input  logic              irq_pend_i,
  input  logic              irq_en_i,
  input  logic [PRIO_W-1:0] irq_prio_i,
  input  logic              wdt_auto_mode_i,
  input  logic              wdt_opt_stop_i,
  input  logic              wdt_reg_stop_i,
  output logic              cpu_clk_en_o,
  output logic              wdt_cnt_en_o,
  output logic              wake_o,
  output logic              mask_set_o
);
  logic qual;
  logic sleep;

  slp_wake_qual #(.PRIO_W(PRIO_W)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (irq_pend_i),
    .en_i   (irq_en_i),
    .prio_i (irq_prio_i),
    .ipl_i  (cpu_ipl_i),
    .qual_o (qual)
  );

  slp_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wait_i     (wait_i),
    .stby_sel_i (stby_sel_i),
    .qual_i     (qual),
    .sleep_o    (sleep),
    .wake_o     (wake_o),
    .mask_set_o (mask_set_o)
  );

  slp_wdt_gate u_wdt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_i     (sleep),
    .auto_mode_i (wdt_auto_mode_i),
    .opt_stop_i  (wdt_opt_stop_i),
    .reg_stop_i  (wdt_reg_stop_i),
    .cnt_en_o    (wdt_cnt_en_o)
  );

  assign cpu_clk_en_o = ~sleep;

  assert_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_set_o |-> (wait_i && !stby_sel_i && cpu_clk_en_o));
endmodule

// File: tb/sim_sleep_wake_ctrl.sv
module sim_sleep_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wait_s = 1'b0, stby = 1'b0;
  logic [3:0] ipl = 4'd0, prio = 4'd0;
  logic       pend = 1'b0, en = 1'b0;
  logic       auto_m = 1'b0, opt_stop = 1'b0, reg_stop = 1'b0;
  logic       clk_en, wdt_en, wake, mask_set;
  int         n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  sleep_wake_ctrl #(.PRIO_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wait_i(wait_s), .stby_sel_i(stby),
    .cpu_ipl_i(ipl), .irq_pend_i(pend), .irq_en_i(en), .irq_prio_i(prio),
    .wdt_auto_mode_i(auto_m), .wdt_opt_stop_i(opt_stop), .wdt_reg_stop_i(reg_stop),
    .cpu_clk_en_o(clk_en), .wdt_cnt_en_o(wdt_en), .wake_o(wake), .mask_set_o(mask_set)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // accepted wait with no pending request; returns asleep
  task automatic go_sleep(input string tag);
    @(negedge clk);
    wait_s = 1'b1; stby = 1'b0; pend = 1'b0;
    #1 chk(mask_set, 1'b1, {tag, " R4 mask on entry"});
    @(negedge clk);
    wait_s = 1'b0;
    chk(clk_en, 1'b0, {tag, " R2 clock stopped"});
  endtask

  task automatic wake_up();
    @(negedge clk);
    pend = 1'b1; en = 1'b1; ipl = 4'd2; prio = 4'd7;
    @(negedge clk);
    pend = 1'b0;
    chk(clk_en, 1'b1, "R6 clock back");
  endtask

  task automatic t_reset();
    chk(clk_en, 1'b1, "R1 clk_en");
    chk(wdt_en, 1'b1, "R1 wdt_en");
    chk(wake, 1'b0, "R1 wake");
    chk(mask_set, 1'b0, "R1 mask_set");
  endtask

  task automatic t_stby();
    @(negedge clk);
    wait_s = 1'b1; stby = 1'b1;
    #1 chk(mask_set, 1'b0, "R3 no mask with standby");
    @(negedge clk);
    wait_s = 1'b0; stby = 1'b0;
    chk(clk_en, 1'b1, "R3 no entry");
  endtask

  task automatic t_enter_hold();
    go_sleep("enter");
    repeat (3) @(negedge clk);
    chk(clk_en, 1'b0, "R2 stays asleep");
    wake_up();
  endtask

  task automatic t_prio_wake();
    go_sleep("prio");
    ipl = 4'd5; prio = 4'd5; en = 1'b1; pend = 1'b1;
    @(negedge clk);
    chk(clk_en, 1'b0, "R5 equal prio no wake");
    prio = 4'd9; en = 1'b0;
    @(negedge clk);
    chk(clk_en, 1'b0, "R5 disabled no wake");
    prio = 4'd3; en = 1'b1;
    @(negedge clk);
    chk(clk_en, 1'b0, "R5 lower prio no wake");
    prio = 4'd6;
    @(negedge clk);
    pend = 1'b0;
    chk(clk_en, 1'b1, "R6 clock on next cycle");
    chk(wake, 1'b1, "R6 wake pulse");
    @(negedge clk);
    chk(wake, 1'b0, "R6 pulse one cycle");
  endtask

  task automatic t_race();
    @(negedge clk);
    wait_s = 1'b1; stby = 1'b0; pend = 1'b1; en = 1'b1; ipl = 4'd1; prio = 4'd4;
    #1 chk(mask_set, 1'b1, "R4 mask with pending");
    @(negedge clk);
    wait_s = 1'b0; pend = 1'b0;
    chk(clk_en, 1'b1, "R7 no entry on race");
    chk(wake, 1'b0, "R7 no wake pulse");
  endtask

  task automatic t_wdt();
    @(negedge clk);
    auto_m = 1'b1; opt_stop = 1'b1; reg_stop = 1'b1;
    #1 chk(wdt_en, 1'b1, "R10 run ignores stop bits");
    go_sleep("wdt");
    auto_m = 1'b1; opt_stop = 1'b1; reg_stop = 1'b0; #1;
    chk(wdt_en, 1'b0, "R8 auto stop");
    opt_stop = 1'b0; reg_stop = 1'b1; #1;
    chk(wdt_en, 1'b1, "R8 auto run, reg bit ignored");
    auto_m = 1'b0; reg_stop = 1'b1; opt_stop = 1'b0; #1;
    chk(wdt_en, 1'b0, "R9 reg stop");
    reg_stop = 1'b0; opt_stop = 1'b1; #1;
    chk(wdt_en, 1'b1, "R9 reg run, opt bit ignored");
    reg_stop = 1'b1;
    wake_up();
    #1 chk(wdt_en, 1'b1, "R10 after wake");
    opt_stop = 1'b0; reg_stop = 1'b0;
  endtask

  task automatic t_sleep_wait();
    go_sleep("sw");
    @(negedge clk);
    wait_s = 1'b1;
    #1 chk(mask_set, 1'b0, "R11 no mask in sleep");
    @(negedge clk);
    wait_s = 1'b0;
    chk(clk_en, 1'b0, "R11 still asleep");
    wake_up();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stby();
    t_enter_hold();
    t_prio_wake();
    t_race();
    t_wdt();
    t_sleep_wait();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule